// File: doc/BRIEF.md
# Programmable Interrupt Request Aggregator

This block gathers 32 interrupt request lines into one interrupt output for a processor. Software configures it through a small register port. For each line, software chooses three things: whether the line is enabled, whether it is detected by level or by edge, and whether it is active high or active low. Lines 0 to 19 carry the four pins of each expansion slot. Lines 20 to 30 are not connected and are held quiet. Line 31 is the cascade request from a secondary legacy controller. A read-only summary word shows every line that is both pending and enabled. A helper output gives the index of the lowest line that is set, which matches the order in which software services requests.

A separate register asks for a system restart. Only one key value, 0x0000DEAD, written to that register produces a one-cycle restart pulse. Any other value written there does nothing.

Top module: `irq_aggregator`

## Requirements
- R1: After reset, every configuration register reads zero and the summary reads zero. The interrupt output, the lowest-valid flag and the restart pulse are all low.
- R2: The register addresses are: 0 for the summary (read-only, writes are ignored), 1 for the enable mask, 2 for the edge select and 3 for the polarity. A value written to address 1, 2 or 3 reads back at once. Address 4 is the clear register and address 5 is the restart register; both read as zero.
- R3: A line counts as active when its input equals its polarity bit. Polarity 1 means active high and polarity 0 means active low.
- R4: With its edge-select bit at 0, a line is level-sensitive. Its pending bit takes the line's active state from the previous clock edge, and writes to the clear register do not change it.
- R5: With its edge-select bit at 1, a line latches pending on an inactive-to-active transition. The latch holds until a 1 is written to that bit of the clear register. If a new transition and a clear of that bit arrive in the same cycle, the bit stays pending.
- R6: A summary bit is the line's pending bit ANDed with its mask bit. A masked edge latch is kept and appears in the summary once the line is enabled.
- R7: Summary bits 20 to 30 are always zero, whatever the inputs and configuration.
- R8: The interrupt output is high exactly when the summary is non-zero.
- R9: When the summary is non-zero, the lowest-valid flag is high and the index output names the lowest set summary bit. Otherwise the flag is low.
- R10: Writing 0x0000DEAD to address 5 drives the restart pulse high for exactly the one cycle after the write edge.
- R11: Any other value written to address 5, and the key value written to any other address, leave the restart pulse low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regWrEn | input | 1 | Write strobe for the register port |
| regAddr | input | 3 | Register address for reads and writes |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for regAddr (combinational) |
| irqLines | input | 32 | Raw request inputs; bit 31 is the cascade |
| irqOut | output | 1 | Combined interrupt request |
| lowestValid | output | 1 | At least one summary bit is set |
| lowestIdx | output | 5 | Index of the lowest set summary bit |
| sysResetPulse | output | 1 | One-cycle restart request |

## Verification
Each result has a known due time:
- A change on irqLines shows in the summary, irqOut and the index outputs after the first rising edge that samples it.
- A configuration write reads back right after its write edge. Any effect it has on the summary also follows from that edge.
- The restart pulse is high in the cycle after the key write edge and low one edge later.

The bench drives inputs 1 ns after a rising edge and updates its own model once per edge. It samples 2 ns after the following edge, so every comparison falls in the cycle where the result is due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Register addresses; the bench and the software both rely on them.
  typedef enum logic [2:0] {
    REG_SUMMARY = 3'd0,
    REG_MASK    = 3'd1,
    REG_EDGE    = 3'd2,
    REG_POL     = 3'd3,
    REG_CLEAR   = 3'd4,
    REG_RESET   = 3'd5
  } regAddr_e;

  // Strobes sent from control to datapath for one write cycle.
  typedef struct packed {
    logic wrMask;
    logic wrEdge;
    logic wrPol;
    logic wrClear;
  } wrStrobes_t;

endpackage

// File: rtl/irq_agg_prienc.sv
module irq_agg_prienc #(
  parameter int NUM_LINES = 32,
  parameter int IDX_W     = $clog2(NUM_LINES)
) (
  input  logic [NUM_LINES-1:0] vec,
  output logic                 valid,
  output logic [IDX_W-1:0]     idx
);

  // Scan from the top down so that the lowest set bit is the last one assigned.
  always_comb begin
    valid = 1'b0;
    idx   = '0;
    for (int i = NUM_LINES - 1; i >= 0; i--) begin
      if (vec[i]) begin
        valid = 1'b1;
        idx   = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/irq_agg_datapath.sv
module irq_agg_datapath
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] RSVD_MASK = '0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  wrStrobes_t           strb,
  input  logic [NUM_LINES-1:0] wrData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic [NUM_LINES-1:0] maskCfg,
  output logic [NUM_LINES-1:0] edgeCfg,
  output logic [NUM_LINES-1:0] polCfg,
  output logic [NUM_LINES-1:0] summaryVec
);

  logic [NUM_LINES-1:0] activeVec;
  logic [NUM_LINES-1:0] prevActive;
  logic [NUM_LINES-1:0] pendReg;
  logic [NUM_LINES-1:0] pendNext;
  logic [NUM_LINES-1:0] clearVec;
  logic [NUM_LINES-1:0] riseVec;

  // Configuration registers.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskCfg <= '0;
      edgeCfg <= '0;
      polCfg  <= '0;
    end else begin
      if (strb.wrMask) maskCfg <= wrData;
      if (strb.wrEdge) edgeCfg <= wrData;
      if (strb.wrPol)  polCfg  <= wrData;
    end
  end

  // Correct each input for its polarity, then find inactive-to-active steps.
  assign activeVec = ~(irqLines ^ polCfg);
  assign riseVec   = activeVec & ~prevActive;
  assign clearVec  = strb.wrClear ? wrData : '0;

  // Edge lines keep their latch unless cleared, and a new rise wins over a clear.
  // Level lines simply take the current active state.
  assign pendNext = ((edgeCfg & ((pendReg & ~clearVec) | riseVec))
                  | (~edgeCfg & activeVec)) & ~RSVD_MASK;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevActive <= '0;
      pendReg    <= '0;
    end else begin
      prevActive <= activeVec;
      pendReg    <= pendNext;
    end
  end

  assign summaryVec = pendReg & maskCfg;

endmodule

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int                   NUM_LINES = 32,
  parameter logic [NUM_LINES-1:0] RESET_KEY = 32'h0000_DEAD
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  input  logic [NUM_LINES-1:0] summaryVec,
  input  logic [NUM_LINES-1:0] maskCfg,
  input  logic [NUM_LINES-1:0] edgeCfg,
  input  logic [NUM_LINES-1:0] polCfg,
  output wrStrobes_t           strb,
  output logic [NUM_LINES-1:0] regRdData,
  output logic                 sysResetPulse
);

  logic keyHit;

  // Turn a write into one strobe per register.
  always_comb begin
    strb         = '0;
    strb.wrMask  = regWrEn && (regAddr == REG_MASK);
    strb.wrEdge  = regWrEn && (regAddr == REG_EDGE);
    strb.wrPol   = regWrEn && (regAddr == REG_POL);
    strb.wrClear = regWrEn && (regAddr == REG_CLEAR);
  end

  // Read mux; the clear and restart registers are write-only.
  always_comb begin
    case (regAddr_e'(regAddr))
      REG_SUMMARY: regRdData = summaryVec;
      REG_MASK:    regRdData = maskCfg;
      REG_EDGE:    regRdData = edgeCfg;
      REG_POL:     regRdData = polCfg;
      default:     regRdData = '0;
    endcase
  end

  // Only the key value written to the restart register fires the pulse.
  assign keyHit = regWrEn && (regAddr == REG_RESET) && (regWrData == RESET_KEY);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) sysResetPulse <= 1'b0;
    else       sysResetPulse <= keyHit;
  end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int          NUM_LINES = 32,
  parameter int          RSVD_LO   = 20,
  parameter int          RSVD_HI   = 30,
  parameter logic [31:0] RESET_KEY = 32'h0000_DEAD,
  localparam int         IDX_W     = $clog2(NUM_LINES)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic [2:0]           regAddr,
  input  logic [NUM_LINES-1:0] regWrData,
  output logic [NUM_LINES-1:0] regRdData,
  input  logic [NUM_LINES-1:0] irqLines,
  output logic                 irqOut,
  output logic                 lowestValid,
  output logic [IDX_W-1:0]     lowestIdx,
  output logic                 sysResetPulse
);

  // Bits RSVD_LO..RSVD_HI inclusive.
  localparam logic [NUM_LINES-1:0] RSVD_MASK =
    (NUM_LINES'(1) << (RSVD_HI + 1)) - (NUM_LINES'(1) << RSVD_LO);

  wrStrobes_t           strb;
  logic [NUM_LINES-1:0] maskCfg;
  logic [NUM_LINES-1:0] edgeCfg;
  logic [NUM_LINES-1:0] polCfg;
  logic [NUM_LINES-1:0] summaryVec;

  irq_agg_ctrl #(
    .NUM_LINES (NUM_LINES),
    .RESET_KEY (NUM_LINES'(RESET_KEY))
  ) i_ctrl (
    .clk           (clk),
    .rstN          (rstN),
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .regWrData     (regWrData),
    .summaryVec    (summaryVec),
    .maskCfg       (maskCfg),
    .edgeCfg       (edgeCfg),
    .polCfg        (polCfg),
    .strb          (strb),
    .regRdData     (regRdData),
    .sysResetPulse (sysResetPulse)
  );

  irq_agg_datapath #(
    .NUM_LINES (NUM_LINES),
    .RSVD_MASK (RSVD_MASK)
  ) i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (regWrData),
    .irqLines   (irqLines),
    .maskCfg    (maskCfg),
    .edgeCfg    (edgeCfg),
    .polCfg     (polCfg),
    .summaryVec (summaryVec)
  );

  irq_agg_prienc #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W)
  ) i_prienc (
    .vec   (summaryVec),
    .valid (lowestValid),
    .idx   (lowestIdx)
  );

  assign irqOut = |summaryVec;

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int                   NUM_LINES = 32,
  parameter int                   IDX_W     = 5,
  parameter logic [NUM_LINES-1:0] RSVD_MASK = '0,
  parameter logic [31:0]          RESET_KEY = 32'h0000_DEAD
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 regWrEn,
  input logic [2:0]           regAddr,
  input logic [NUM_LINES-1:0] regWrData,
  input logic [NUM_LINES-1:0] summaryVec,
  input logic                 irqOut,
  input logic                 lowestValid,
  input logic [IDX_W-1:0]     lowestIdx,
  input logic                 sysResetPulse
);

  logic keyWrite;
  assign keyWrite = regWrEn && (regAddr == 3'd5) && (regWrData == NUM_LINES'(RESET_KEY));

  // R7
  rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (summaryVec & RSVD_MASK) == '0);

  // R10
  key_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyWrite |=> sysResetPulse);

  // R11
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rstN)
    sysResetPulse |-> $past(keyWrite));

  // R9
  lowest_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowestValid |-> summaryVec[lowestIdx]);

  // R9
  lowest_below_chk: assert property (@(posedge clk) disable iff (!rstN)
    lowestValid |-> ((summaryVec << (NUM_LINES - int'(lowestIdx))) == '0));

  // R8
  irq_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == lowestValid);

endmodule

bind irq_aggregator irq_agg_chk #(
  .NUM_LINES (NUM_LINES),
  .IDX_W     (IDX_W),
  .RSVD_MASK (RSVD_MASK),
  .RESET_KEY (RESET_KEY)
) i_chk (
  .clk           (clk),
  .rstN          (rstN),
  .regWrEn       (regWrEn),
  .regAddr       (regAddr),
  .regWrData     (regWrData),
  .summaryVec    (summaryVec),
  .irqOut        (irqOut),
  .lowestValid   (lowestValid),
  .lowestIdx     (lowestIdx),
  .sysResetPulse (sysResetPulse)
);

// File: tb/test_irq_aggregator.sv
`timescale 1ns/100ps
module test_irq_aggregator;

  localparam logic [31:0] KEY  = 32'h0000_DEAD;
  localparam logic [31:0] RSVD = 32'h7FF0_0000;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = 3'd0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic [31:0] irqLines = '1;
  logic        irqOut, lowestValid, sysResetPulse;
  logic [4:0]  lowestIdx;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic [31:0] mMask = '0, mEdge = '0, mPol = '0, mPend = '0, mPrev = '0;
  bit          mPulse = 0;

  always #2.5 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .irqLines(irqLines),
    .irqOut(irqOut), .lowestValid(lowestValid), .lowestIdx(lowestIdx),
    .sysResetPulse(sysResetPulse)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Advance one edge and update the bench model from the requirements.
  task automatic tick();
    logic [31:0] act, clr, nxt;
    act = ~(irqLines ^ mPol);
    clr = (regWrEn && regAddr == 3'd4) ? regWrData : '0;
    nxt = ((mEdge & ((mPend & ~clr) | (act & ~mPrev))) | (~mEdge & act)) & ~RSVD;
    mPrev = act;
    mPend = nxt;
    mPulse = regWrEn && regAddr == 3'd5 && regWrData == KEY;
    if (regWrEn && regAddr == 3'd1) mMask = regWrData;
    if (regWrEn && regAddr == 3'd2) mEdge = regWrData;
    if (regWrEn && regAddr == 3'd3) mPol  = regWrData;
    @(posedge clk);
    #1;
    regWrEn = 1'b0;
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
  endtask

  task automatic checkAll(string tag);
    logic [31:0] sum;
    bit          v;
    logic [4:0]  ix;
    sum = mPend & mMask;
    v = 0; ix = '0;
    for (int i = 31; i >= 0; i--) if (sum[i]) begin v = 1; ix = 5'(i); end
    regAddr = 3'd0;
    #1;
    check({tag, " summary"}, regRdData, sum);
    check({tag, " R8 irqOut"}, 32'(irqOut), 32'(sum != 0));
    check({tag, " R9 valid"}, 32'(lowestValid), 32'(v));
    if (v) check({tag, " R9 idx"}, 32'(lowestIdx), 32'(ix));
  endtask

  task automatic rd(string tag, logic [2:0] a, logic [31:0] exp);
    regAddr = a;
    #1;
    check(tag, regRdData, exp);
  endtask

  initial begin
    #(5 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    for (int a = 0; a < 6; a++) rd("R1 reset read", 3'(a), '0);
    check("R1 irqOut", 32'(irqOut), 0);
    check("R1 pulse", 32'(sysResetPulse), 0);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    checkAll("R1");

    // R2 register readback
    wr(3'd1, 32'hA5A5_5A5A); rd("R2 mask", 3'd1, 32'hA5A5_5A5A);
    wr(3'd2, 32'h0F0F_F0F0); rd("R2 edge", 3'd2, 32'h0F0F_F0F0);
    wr(3'd3, 32'h3C3C_C3C3); rd("R2 pol", 3'd3, 32'h3C3C_C3C3);
    rd("R2 clear reads zero", 3'd4, '0);
    rd("R2 reset reads zero", 3'd5, '0);
    irqLines = ~mPol; tick(); tick();
    checkAll("R2 idle");
    wr(3'd0, 32'hFFFF_FFFF);
    checkAll("R2 summary write ignored");

    // Per-line sweep over edge/level and both polarities (R3 R4 R5 R7)
    for (int e = 0; e < 2; e++)
      for (int p = 0; p < 2; p++)
        for (int i = 0; i < 32; i++) begin
          string tg;
          logic [31:0] idle;
          tg = (i >= 20 && i <= 30) ? "R7" : (e ? (p ? "R5 R3 high" : "R5 R3 low")
                                                : (p ? "R4 R3 high" : "R4 R3 low"));
          idle = p ? '0 : '1;
          wr(3'd1, '1);
          wr(3'd2, e ? '1 : '0);
          wr(3'd3, p ? '1 : '0);
          irqLines = idle; tick(); tick();
          wr(3'd4, '1);
          checkAll(tg);
          irqLines[i] = p[0];
          tick(); checkAll(tg);
          tick(); checkAll(tg);
          irqLines = idle;
          tick(); checkAll(tg);
          wr(3'd4, ~(32'd1 << i)); checkAll(tg);
          wr(3'd4, 32'd1 << i);    checkAll(tg);
        end

    // R6 masked edge latch survives and shows once enabled
    wr(3'd3, '1); wr(3'd2, '1); irqLines = '0; tick();
    wr(3'd4, '1); wr(3'd1, '0);
    irqLines[5] = 1'b1; tick(); irqLines[5] = 1'b0; tick();
    checkAll("R6 masked");
    check("R6 masked irqOut", 32'(irqOut), 0);
    wr(3'd1, 32'd1 << 5);
    checkAll("R6 unmasked");
    check("R6 shows line 5", regRdData, 32'd1 << 5);

    // R5 rising edge and clear of the same bit in one cycle: set wins
    wr(3'd1, '1); wr(3'd4, '1);
    irqLines = 32'd1 << 9; regWrEn = 1'b1; regAddr = 3'd4; regWrData = 32'd1 << 9;
    tick();
    checkAll("R5 set beats clear");
    check("R5 line 9 pending", regRdData & (32'd1 << 9), 32'd1 << 9);

    // Mixed random configuration (R3 R4 R5 R8 R9)
    for (int n = 0; n < 400; n++) begin
      if (n % 16 == 0) begin
        wr(3'd1, $urandom); wr(3'd2, $urandom); wr(3'd3, $urandom);
      end
      if (n % 5 == 0) wr(3'd4, $urandom);
      irqLines = $urandom & $urandom;
      tick();
      checkAll("R8 R9 R3 mixed");
    end

    // R10 key write pulses for one cycle
    wr(3'd5, KEY);
    check("R10 pulse high", 32'(sysResetPulse), 32'(mPulse));
    check("R10 pulse value", 32'(sysResetPulse), 1);
    tick();
    check("R10 pulse one cycle", 32'(sysResetPulse), 0);
    // R11 wrong values or wrong address
    wr(3'd5, 32'h0000_DEAE); check("R11 near key", 32'(sysResetPulse), 0);
    wr(3'd5, 32'hFFFF_DEAD); check("R11 upper bits", 32'(sysResetPulse), 0);
    wr(3'd4, KEY);           check("R11 key at clear", 32'(sysResetPulse), 0);
    wr(3'd1, KEY);           check("R11 key at mask", 32'(sysResetPulse), 0);
    checkAll("R11 state");

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule